// File: doc/BRIEF.md
# GPIO Port with SPI Pin Overrides

An 8-bit general-purpose I/O port. Software writes an output-data register and a direction register, and reads back either register or the synchronized pin levels. Four low pins can be claimed by an SPI peripheral: pin 0 is slave select, pin 1 is the serial clock, pin 2 is master-out/slave-in, and pin 3 is master-in/slave-out. Pins 4 to 6 can carry timer compare or PWM outputs. Pin 7 is plain GPIO.

For every pin, the block decides three things from the SPI enable, the SPI role and the software registers: whether the pad driver is on, which value it drives, and whether the pull-up is on. The SPI role forces some pins to be inputs and ignores their direction bits. The pull-up of such a forced input stays under software control through the output-data bit.

Pad inputs pass through a two-flop synchronizer. The synchronized levels feed the pin-read register and the SPI receive signals. The block also flags when a slave SPI is selected. The shift engine and the timers are outside the block and appear only as signals. All register and SPI signals are plain level or strobe pins with no handshake. A register write takes effect on the next clock edge and cannot be stalled.

Top module: `gpio_spi_port`

## Requirements
- R1: All registers reset to zero. A write with address 0 loads the output-data register and a write with address 1 loads the direction register, both on the next edge. Writes with address 2 or 3 change nothing. A read with address 0 returns output data, address 1 returns direction, address 2 returns the synchronized pins, and address 3 returns zero.
- R2: With SPI disabled, pins 0 to 3 and pin 7 have `pad_oe` equal to their direction bit and `pad_out` equal to their output-data bit.
- R3: With SPI enabled as master, pin 3 is always an input. Pins 0, 1 and 2 take their driver enable from their direction bits. A driven pin 1 outputs `spi_sck_out`, a driven pin 2 outputs `spi_mosi_out`, and a driven pin 0 outputs its output-data bit.
- R4: With SPI enabled as slave, pins 0, 1 and 2 are always inputs. Pin 3 takes its driver enable from its direction bit and, when driven, outputs `spi_miso_out`.
- R5: `pad_pu[i]` is 1 exactly when pin i is not driven and its output-data bit is 1. This includes pins forced to input by the SPI role.
- R6: For k in 0..2, pin 4+k is driven when its direction bit is 1. It outputs `tmr_cmp[k]` when `tmr_en[k]` is 1, and its output-data bit otherwise.
- R7: A level on `pad_in` appears on read address 2 and on `spi_ss_in`, `spi_sck_in`, `spi_mosi_in` and `spi_miso_in` (pins 0, 1, 2 and 3) after exactly two rising clock edges.
- R8: `spi_slave_active` is 1 exactly when SPI is enabled, the role is slave, and the synchronized pin 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Write address (0 output data, 1 direction) |
| reg_wr_data | input | 8 | Write data |
| reg_rd_addr | input | 2 | Read address (0 data, 1 direction, 2 pins, 3 zero) |
| reg_rd_data | output | 8 | Read data, combinational from address |
| spi_en | input | 1 | SPI peripheral enabled |
| spi_master | input | 1 | SPI role: 1 master, 0 slave |
| spi_sck_out | input | 1 | Serial clock from the SPI master engine |
| spi_mosi_out | input | 1 | Master transmit data |
| spi_miso_out | input | 1 | Slave transmit data |
| spi_ss_in | output | 1 | Synchronized pin 0 |
| spi_sck_in | output | 1 | Synchronized pin 1 |
| spi_mosi_in | output | 1 | Synchronized pin 2 (slave receive) |
| spi_miso_in | output | 1 | Synchronized pin 3 (master receive) |
| spi_slave_active | output | 1 | Slave role selected by a low select pin |
| tmr_en | input | 3 | Compare output enables for pins 4..6 |
| tmr_cmp | input | 3 | Compare output levels for pins 4..6 |
| pad_in | input | 8 | Raw pad levels |
| pad_out | output | 8 | Pad drive values |
| pad_oe | output | 8 | Pad driver enables |
| pad_pu | output | 8 | Pad pull-up enables |

## Verification
The bench switches the SPI role while the direction bits for the forced pins stay at 1. A design that obeyed those bits would drive slave-select or clock against an external master, and the driver-enable comparison reports this. It sets output-data bits on forced inputs to catch a pull-up tied to the direction bit instead of the effective direction. It checks that a slave-select edge reaches the active flag only through the synchronizer. It compares read data against a two-deep history, so a synchronizer one stage short or long shows up at once. With a timer enabled and its direction bit at 0, it confirms the pin stays undriven, and it confirms that writes to addresses 2 and 3 leave both registers alone.

// File: rtl/gpio_spi_pkg.sv
package gpio_spi_pkg;
  localparam int PIN_SS   = 0;
  localparam int PIN_SCK  = 1;
  localparam int PIN_MOSI = 2;
  localparam int PIN_MISO = 3;
  localparam int PIN_TMR0 = 4;

  typedef enum logic [1:0] {
    REG_OUT  = 2'd0,
    REG_DIR  = 2'd1,
    REG_PIN  = 2'd2,
    REG_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_spi_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] port_q,
  output logic [W-1:0] dir_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      port_q <= '0;
      dir_q  <= '0;
    end else if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        REG_OUT: port_q <= wr_data;
        REG_DIR: dir_q  <= wr_data;
        default: ;
      endcase
    end
  end

  AST_OUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0) |=> (port_q == $past(wr_data))); // R1
  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd1) |=> (dir_q == $past(wr_data))); // R1
  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || wr_addr[1]) |=> ($stable(port_q) && $stable(dir_q))); // R1
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[g] <= '0;
      else        stg[g] <= stg[g-1];
    end
  end

  assign dout = stg[STAGES-1];

  logic [3:0] warm;
  always_ff @(posedge clk) begin
    if (!rst_n)                 warm <= '0;
    else if (warm < 4'(STAGES)) warm <= warm + 4'd1;
  end

  AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 4'(STAGES)) |-> (dout == $past(din, STAGES))); // R7
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_spi_pkg::*;
#(
  parameter int W     = 8,
  parameter int TMR_N = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     port_q,
  input  logic [W-1:0]     dir_q,
  input  logic             spi_en,
  input  logic             spi_master,
  input  logic             sck_o,
  input  logic             mosi_o,
  input  logic             miso_o,
  input  logic [TMR_N-1:0] tmr_en,
  input  logic [TMR_N-1:0] tmr_cmp,
  output logic [W-1:0]     oe,
  output logic [W-1:0]     dout,
  output logic [W-1:0]     pu
);
  always_comb begin
    oe   = dir_q;
    dout = port_q;
    if (spi_en) begin
      if (spi_master) begin
        oe[PIN_MISO]   = 1'b0;
        dout[PIN_SCK]  = sck_o;
        dout[PIN_MOSI] = mosi_o;
      end else begin
        oe[PIN_SS]     = 1'b0;
        oe[PIN_SCK]    = 1'b0;
        oe[PIN_MOSI]   = 1'b0;
        dout[PIN_MISO] = miso_o;
      end
    end
    for (int k = 0; k < TMR_N; k++) begin
      if (tmr_en[k]) dout[PIN_TMR0+k] = tmr_cmp[k];
    end
  end

  assign pu = ~oe & port_q;

  AST_GPIO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_en |-> (oe[3:0] == dir_q[3:0] && dout[3:0] == port_q[3:0])); // R2
  AST_MASTER_MISO_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && spi_master) |-> !oe[PIN_MISO]); // R3
  AST_MASTER_SCK_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && spi_master && dir_q[PIN_SCK]) |-> (oe[PIN_SCK] && dout[PIN_SCK] == sck_o)); // R3
  AST_SLAVE_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && !spi_master) |-> (oe[2:0] == 3'b000)); // R4
  AST_SLAVE_MISO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && !spi_master && dir_q[PIN_MISO]) |-> (dout[PIN_MISO] == miso_o)); // R4
  AST_PU_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((pu & oe) == '0)); // R5
  AST_TMR_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_en[0] && dir_q[PIN_TMR0]) |-> (oe[PIN_TMR0] && dout[PIN_TMR0] == tmr_cmp[0])); // R6
endmodule

// File: rtl/gpio_spi_port.sv
module gpio_spi_port
  import gpio_spi_pkg::*;
#(
  parameter int W      = 8,
  parameter int TMR_N  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [1:0]       reg_wr_addr,
  input  logic [W-1:0]     reg_wr_data,
  input  logic [1:0]       reg_rd_addr,
  output logic [W-1:0]     reg_rd_data,
  input  logic             spi_en,
  input  logic             spi_master,
  input  logic             spi_sck_out,
  input  logic             spi_mosi_out,
  input  logic             spi_miso_out,
  output logic             spi_ss_in,
  output logic             spi_sck_in,
  output logic             spi_mosi_in,
  output logic             spi_miso_in,
  output logic             spi_slave_active,
  input  logic [TMR_N-1:0] tmr_en,
  input  logic [TMR_N-1:0] tmr_cmp,
  input  logic [W-1:0]     pad_in,
  output logic [W-1:0]     pad_out,
  output logic [W-1:0]     pad_oe,
  output logic [W-1:0]     pad_pu
);
  logic [W-1:0] port_q, dir_q, pin_s;

  gpio_port_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_addr(reg_wr_addr),
    .wr_data(reg_wr_data), .port_q(port_q), .dir_q(dir_q)
  );

  gpio_in_sync #(.W(W), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(pin_s)
  );

  gpio_pin_mux #(.W(W), .TMR_N(TMR_N)) u_mux (
    .clk(clk), .rst_n(rst_n), .port_q(port_q), .dir_q(dir_q),
    .spi_en(spi_en), .spi_master(spi_master), .sck_o(spi_sck_out),
    .mosi_o(spi_mosi_out), .miso_o(spi_miso_out), .tmr_en(tmr_en),
    .tmr_cmp(tmr_cmp), .oe(pad_oe), .dout(pad_out), .pu(pad_pu)
  );

  assign spi_ss_in        = pin_s[PIN_SS];
  assign spi_sck_in       = pin_s[PIN_SCK];
  assign spi_mosi_in      = pin_s[PIN_MOSI];
  assign spi_miso_in      = pin_s[PIN_MISO];
  assign spi_slave_active = spi_en && !spi_master && !pin_s[PIN_SS];

  always_comb begin
    case (reg_addr_e'(reg_rd_addr))
      REG_OUT: reg_rd_data = port_q;
      REG_DIR: reg_rd_data = dir_q;
      REG_PIN: reg_rd_data = pin_s;
      default: reg_rd_data = '0;
    endcase
  end

  AST_SLAVE_ROLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    spi_slave_active |-> (spi_en && !spi_master && !spi_ss_in)); // R8
  AST_SLAVE_IDLE_HIGH_SS: assert property (@(posedge clk) disable iff (!rst_n)
    spi_ss_in |-> !spi_slave_active); // R8
endmodule

// File: tb/gpio_spi_port_bench.sv
`timescale 1ns/1ps
module gpio_spi_port_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n;
  logic       reg_wr_en;
  logic [1:0] reg_wr_addr, reg_rd_addr;
  logic [7:0] reg_wr_data, reg_rd_data;
  logic       spi_en, spi_master, spi_sck_out, spi_mosi_out, spi_miso_out;
  logic       spi_ss_in, spi_sck_in, spi_mosi_in, spi_miso_in, spi_slave_active;
  logic [2:0] tmr_en, tmr_cmp;
  logic [7:0] pad_in, pad_out, pad_oe, pad_pu;

  gpio_spi_port u_gpio_spi_port (.*);

  int checks = 0, failures = 0;
  bit done = 0;

  // behavioural reference state
  bit [7:0] m_port, m_dir, m_s1, m_s2;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_port = 0; m_dir = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      m_s2 = m_s1;
      m_s1 = pad_in;
      if (reg_wr_en && reg_wr_addr == 2'd0) m_port = reg_wr_data;
      if (reg_wr_en && reg_wr_addr == 2'd1) m_dir  = reg_wr_data;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit [7:0] e_oe, e_out, msk, e_rd;
    string mt;
    mt = !spi_en ? "R2" : (spi_master ? "R3" : "R4");
    for (int i = 0; i < 8; i++) begin
      e_oe[i]  = m_dir[i];
      e_out[i] = m_port[i];
      if (spi_en && spi_master) begin
        if (i == 3) e_oe[i] = 0;
        if (i == 1) e_out[i] = spi_sck_out;
        if (i == 2) e_out[i] = spi_mosi_out;
      end
      if (spi_en && !spi_master) begin
        if (i <= 2) e_oe[i] = 0;
        if (i == 3) e_out[i] = spi_miso_out;
      end
      if (i >= 4 && i <= 6 && tmr_en[i-4]) e_out[i] = tmr_cmp[i-4];
    end
    chk({mt, " pad_oe[3:0]"}, {4'h0, pad_oe[3:0]}, {4'h0, e_oe[3:0]});
    chk("R2 pad_oe[7]", {7'h0, pad_oe[7]}, {7'h0, e_oe[7]});
    chk("R6 pad_oe[6:4]", {5'h0, pad_oe[6:4]}, {5'h0, e_oe[6:4]});
    msk = e_oe;
    chk({mt, " pad_out driven[3:0]"}, {4'h0, pad_out[3:0] & msk[3:0]}, {4'h0, e_out[3:0] & msk[3:0]});
    chk("R6 pad_out driven[6:4]", {5'h0, pad_out[6:4] & msk[6:4]}, {5'h0, e_out[6:4] & msk[6:4]});
    chk("R5 pad_pu", pad_pu, ~e_oe & m_port);
    case (reg_rd_addr)
      2'd0: e_rd = m_port;
      2'd1: e_rd = m_dir;
      2'd2: e_rd = m_s2;
      default: e_rd = 0;
    endcase
    chk(reg_rd_addr == 2'd2 ? "R7 read pins" : "R1 read reg", reg_rd_data, e_rd);
    chk("R7 spi inputs", {4'h0, spi_miso_in, spi_mosi_in, spi_sck_in, spi_ss_in}, {4'h0, m_s2[3:0]});
    chk("R8 slave active", {7'h0, spi_slave_active}, {7'h0, spi_en && !spi_master && !m_s2[0]});
  endtask

  task automatic drive(int cyc);
    int ph;
    ph = cyc / 400;
    reg_wr_en    = ($urandom % 4) == 0;
    reg_wr_addr  = 2'($urandom);
    reg_wr_data  = 8'($urandom);
    reg_rd_addr  = 2'($urandom);
    pad_in       = 8'($urandom);
    spi_sck_out  = 1'($urandom);
    spi_mosi_out = 1'($urandom);
    spi_miso_out = 1'($urandom);
    tmr_cmp      = 3'($urandom);
    case (ph)
      0: begin spi_en = 0; spi_master = 1'($urandom); tmr_en = 0; end
      1: begin spi_en = 1; spi_master = 1; tmr_en = 0; end
      2: begin spi_en = 1; spi_master = 0; tmr_en = 0; end
      3: begin spi_en = 0; spi_master = 0; tmr_en = 3'($urandom); end
      default: begin
        spi_en = 1'($urandom); spi_master = 1'($urandom); tmr_en = 3'($urandom);
      end
    endcase
    // R3/R4: at phase starts, force all direction bits on so forced pins are tested
    if (cyc % 400 == 0) begin
      reg_wr_en = 1; reg_wr_addr = 2'd1; reg_wr_data = 8'hFF;
    end
    if (cyc % 400 == 1) begin
      reg_wr_en = 1; reg_wr_addr = 2'd0; reg_wr_data = 8'hFF;
    end
  endtask

  initial begin
    rst_n = 0; reg_wr_en = 0; reg_wr_addr = 0; reg_wr_data = 0; reg_rd_addr = 0;
    spi_en = 0; spi_master = 0; spi_sck_out = 0; spi_mosi_out = 0; spi_miso_out = 0;
    tmr_en = 0; tmr_cmp = 0; pad_in = 8'hA5;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 reset oe", pad_oe, 8'h00);
    chk("R1 reset pu", pad_pu, 8'h00);
    chk("R1 reset rd", reg_rd_data, 8'h00);
    rst_n = 1;
    for (int c = 0; c < 2000; c++) begin
      @(negedge clk);
      compare();
      drive(c);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule